// File: doc/BRIEF.md
# Edge-Timing Entropy Collector

This block harvests random bits from a one-bit digitized noise source, such as a comparator behind a reverse-biased junction. It does not sample the noise level itself. A free-running cycle counter runs all the time. Each time the noise line makes a low-to-high transition, the parity of that counter becomes one new entropy bit. Because the gaps between noise edges are irregular, the parity seen at each edge is unpredictable.

The noise pin is asynchronous. It passes through a synchronizer, and then an edge detector picks out rising transitions. Every detected edge shifts one bit into a word-wide entropy register. After every full word of fresh bits, the completed word is offered on a parallel output for exactly one cycle, together with a valid strobe.

The output stream has no ready input and no back-pressure. A consumer that wants the words must take each one in the cycle its valid is high. The word stays on the output pins until the next word replaces it. A separate debug output copies the live entropy register at a slow fixed interval, a few times per second at the default 50 MHz clock, so that the register can drive indicator LEDs. That copy holds steady between refreshes.

Top module: `edge_entropy_collector`

## Requirements
- R1: While `rst` is high at a clock edge, the entropy register, the bit count, the output word, the valid strobe, the debug copy, the synchronizer and edge history, the cycle counter and the refresh timer are all cleared to zero.
- R2: Only a low-to-high transition of the synchronized noise is an event. A high level held steady, a low level held steady and a high-to-low transition each leave the entropy register unchanged.
- R3: `noise_in` is first captured at clock k. It passes two synchronizer flops, so its rising edge is detected during the cycle after clock k+1, and the entropy bit is inserted at clock k+2.
- R4: The inserted bit is bit 0 of a cycle counter. After reset, that counter advances by one on every clock. It is never reloaded or cleared by an event.
- R5: An event shifts the entropy register left by one place. The new bit enters at bit 0 and the previous top bit is dropped.
- R6: On the 32nd event since the previous word, or since reset, `ent_word_o` takes the full register value including the new bit. `ent_valid_o` is then high for exactly one cycle. `ent_word_o` does not change while `ent_valid_o` is low.
- R7: Rising edges at the minimum spacing of two cycles (noise toggling every clock) each count as a separate event.
- R8: Every `DBG_INTERVAL` clocks after reset, `dbg_word_o` loads the entropy register value from just before that clock. Between loads, `dbg_word_o` holds.
- R9: A reset in the middle of a word discards the partial bits. The first word after reset needs a full 32 new events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| noise_in | input | 1 | Asynchronous digitized noise bit |
| ent_word_o | output | ENT_W (32) | Last completed entropy word |
| ent_valid_o | output | 1 | One-cycle strobe: a new word is present |
| dbg_word_o | output | ENT_W (32) | Slowly refreshed copy of the entropy register |

## Verification
The bench drives noise toggling every cycle, the densest edge rate. A detector that missed closely spaced edges, or that counted levels instead of edges, would produce fewer words or words that are not constant. At that rate every edge falls on the same counter parity, so each word must be all zeros or all ones. Long steady highs and lows, and isolated falling edges, are also driven. A design that counted falling edges or levels would shift in extra bits, and the expected debug copies and words would not match. A reset is applied partway through a word. A design that kept the stale bit count would emit a word before 32 new edges had arrived. Random noise with irregular gaps checks the synchronizer latency and the counter parity on every bit.

// File: rtl/ec_pkg.sv
package ec_pkg;
  localparam int ENT_W_DEF   = 32;
  localparam int CNT_W_DEF   = 16;
  localparam int CLK_HZ_DEF  = 50_000_000;
  localparam int DBG_HZ_DEF  = 4;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/ec_sync_edge.sv
module ec_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic noise_in,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], noise_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ec_collector.sv
module ec_collector #(
  parameter int ENT_W = 32,
  parameter int CNT_W = 16,
  localparam int BCW  = $clog2(ENT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  output logic [ENT_W-1:0] ent_o,
  output logic [BCW-1:0]   bits_o,
  output logic [ENT_W-1:0] word_o,
  output logic             valid_o
);
  logic [CNT_W-1:0] free_cnt;
  logic [ENT_W-1:0] ent_q, ent_nxt;
  logic [BCW-1:0]   bits_q;
  logic             last_bit;

  assign ent_nxt  = {ent_q[ENT_W-2:0], free_cnt[0]};
  assign last_bit = (bits_q == BCW'(ENT_W - 1));

  always_ff @(posedge clk) begin
    if (rst) free_cnt <= '0;
    else     free_cnt <= free_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q   <= '0;
      bits_q  <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (edge_i) begin
        ent_q <= ent_nxt;
        if (last_bit) begin
          bits_q  <= '0;
          word_o  <= ent_nxt;
          valid_o <= 1'b1;
        end else begin
          bits_q <= bits_q + 1'b1;
        end
      end
    end
  end

  assign ent_o  = ent_q;
  assign bits_o = bits_q;
endmodule

// File: rtl/ec_debug_snap.sv
module ec_debug_snap #(
  parameter int ENT_W    = 32,
  parameter int INTERVAL = 12_500_000,
  localparam int TW      = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENT_W-1:0] ent_i,
  output logic             tick_o,
  output logic [ENT_W-1:0] dbg_o
);
  logic [TW-1:0] timer_q;

  assign tick_o = (timer_q == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
      dbg_o   <= '0;
    end else if (tick_o) begin
      timer_q <= '0;
      dbg_o   <= ent_i;
    end else begin
      timer_q <= timer_q + 1'b1;
    end
  end
endmodule

// File: rtl/edge_entropy_collector.sv
module edge_entropy_collector #(
  parameter int ENT_W        = ec_pkg::ENT_W_DEF,
  parameter int CNT_W        = ec_pkg::CNT_W_DEF,
  parameter int CLK_HZ       = ec_pkg::CLK_HZ_DEF,
  parameter int DBG_HZ       = ec_pkg::DBG_HZ_DEF,
  parameter int DBG_INTERVAL = CLK_HZ / DBG_HZ
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             noise_in,
  output logic [ENT_W-1:0] ent_word_o,
  output logic             ent_valid_o,
  output logic [ENT_W-1:0] dbg_word_o
);
  localparam int BCW = $clog2(ENT_W);

  logic             edge_w;
  logic [ENT_W-1:0] ent_w;
  logic [BCW-1:0]   bcnt_w;
  logic             tick_w;

  ec_sync_edge #(.STAGES(ec_pkg::SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .noise_in(noise_in), .edge_o(edge_w)
  );

  ec_collector #(.ENT_W(ENT_W), .CNT_W(CNT_W)) u_coll (
    .clk(clk), .rst(rst), .edge_i(edge_w), .ent_o(ent_w), .bits_o(bcnt_w),
    .word_o(ent_word_o), .valid_o(ent_valid_o)
  );

  ec_debug_snap #(.ENT_W(ENT_W), .INTERVAL(DBG_INTERVAL)) u_dbg (
    .clk(clk), .rst(rst), .ent_i(ent_w), .tick_o(tick_w), .dbg_o(dbg_word_o)
  );
endmodule

// File: rtl/ec_checker.sv
module ec_checker #(
  parameter int ENT_W = 32,
  parameter int BCW   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             edge_pulse,
  input logic [ENT_W-1:0] ent_reg,
  input logic [BCW-1:0]   bit_cnt,
  input logic [ENT_W-1:0] word,
  input logic             valid,
  input logic             tick,
  input logic [ENT_W-1:0] dbg
);
  AST_ENT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    !edge_pulse |=> $stable(ent_reg)); // R2
  AST_ENT_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> ent_reg[ENT_W-1:1] == $past(ent_reg[ENT_W-2:0])); // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R6
  AST_VALID_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    valid |-> bit_cnt == '0); // R6
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(word)); // R6
  AST_DBG_HELD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dbg)); // R8
  AST_DBG_LOAD: assert property (@(posedge clk) disable iff (rst)
    tick |=> dbg == $past(ent_reg)); // R8
endmodule

bind edge_entropy_collector ec_checker #(.ENT_W(ENT_W), .BCW(BCW)) u_chk (
  .clk(clk), .rst(rst), .edge_pulse(edge_w), .ent_reg(ent_w), .bit_cnt(bcnt_w),
  .word(ent_word_o), .valid(ent_valid_o), .tick(tick_w), .dbg(dbg_word_o)
);

// File: tb/edge_entropy_collector_test.sv
module edge_entropy_collector_test;
  localparam int W     = 32;
  localparam int DBG_N = 97;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         noise = 1'b0;
  logic [W-1:0] word, dbg;
  logic         valid;

  int checks = 0;
  int fails  = 0;

  edge_entropy_collector #(.ENT_W(W), .DBG_INTERVAL(DBG_N)) uut (
    .clk(clk), .rst(rst), .noise_in(noise),
    .ent_word_o(word), .ent_valid_o(valid), .dbg_word_o(dbg)
  );

  always #4 clk = ~clk;

  // Reference model built from the requirements
  logic         m_s1, m_s2, m_prev;
  logic [15:0]  m_cnt;
  logic [W-1:0] m_ent, m_word, m_dbg;
  logic         m_valid;
  int           m_bits, m_tmr, edges_since_rst, words_seen;

  function automatic logic [W-1:0] push_bit(logic [W-1:0] r, logic b);
    return {r[W-2:0], b};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_cnt <= 0; m_ent <= 0; m_word <= 0;
      m_valid <= 0; m_bits <= 0; m_tmr <= 0; m_dbg <= 0; edges_since_rst <= 0;
    end else begin
      m_s1 <= noise; m_s2 <= m_s1; m_prev <= m_s2;  // R3 two-stage latency
      m_cnt <= m_cnt + 1'b1;                         // R4 free-running
      m_valid <= 1'b0;
      if (m_s2 && !m_prev) begin                     // R2 rising only
        m_ent <= push_bit(m_ent, m_cnt[0]);          // R5
        edges_since_rst <= edges_since_rst + 1;
        if (m_bits == W - 1) begin
          m_bits <= 0; m_valid <= 1'b1; m_word <= push_bit(m_ent, m_cnt[0]);
        end else m_bits <= m_bits + 1;
      end
      if (m_tmr == DBG_N - 1) begin m_tmr <= 0; m_dbg <= m_ent; end
      else m_tmr <= m_tmr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  bit in_toggle = 0;

  // Per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (!rst) begin
      check(valid == m_valid, "R6 valid", {31'd0, valid}, {31'd0, m_valid});
      check(word == m_word, "R4/R5 word", word, m_word);
      check(dbg == m_dbg, "R8 debug copy", dbg, m_dbg);
      if (m_valid) begin
        words_seen++;
        if (in_toggle) begin
          check(word == '0 || word == '1, "R7 dense edges same parity", word, m_word);
          if (words_seen == 1)
            check(edges_since_rst == 32, "R9 full word after reset",
                  W'(edges_since_rst), W'(32));
        end
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    do_summary();
  end

  initial begin
    void'($urandom(32'd4242));
    cycles(4);
    // R1 reset state
    check(word == '0, "R1 word reset", word, '0);
    check(valid == 1'b0, "R1 valid reset", {31'd0, valid}, '0);
    check(dbg == '0, "R1 debug reset", dbg, '0);
    rst = 1'b0;

    // R2 steady levels and falling edges: hold high, drop, hold low
    noise = 1'b1; cycles(300);
    noise = 1'b0; cycles(300);
    noise = 1'b1; cycles(5);
    noise = 1'b0; cycles(250);

    // R3/R4 random irregular gaps
    for (int i = 0; i < 4000; i++) begin
      noise = ~noise;
      cycles(1 + ($urandom % 7));
    end

    // R9 reset mid-word, then R7 toggle every cycle
    for (int i = 0; i < 11; i++) begin noise = ~noise; cycles(3); end
    rst = 1'b1; cycles(3);
    noise = 1'b0;
    words_seen = 0; in_toggle = 1;
    rst = 1'b0;
    for (int i = 0; i < 200; i++) begin noise = ~noise; cycles(1); end
    noise = 1'b0; cycles(10);
    in_toggle = 0;
    check(words_seen >= 3, "R7 dense edge word count", W'(words_seen), W'(3));

    // more random bursts of mixed spacing
    for (int i = 0; i < 3000; i++) begin
      noise = ($urandom % 3) != 0 ? ~noise : noise;
      cycles(1 + ($urandom % 3));
    end
    cycles(2 * DBG_N);
    do_summary();
  end
endmodule